// File: doc/BRIEF.md
# Two-Level Breakpoint Trigger Unit

This block watches a processor's instruction fetch and operand bus traffic without stopping the processor. Each cycle it checks the traffic against three programmable conditions: a program counter value under a bit mask, an operand address inside an inclusive window, and an operand data value under a bit mask. A trigger definition register picks which conditions are armed at the first level and at the second level. It also selects whether the unit runs as a one-level trigger or as a chained two-level trigger.

The unit keeps a 4-bit breakpoint status. Whenever the 4-bit debug data port is not carrying trace information, the unit drives an encoded copy of that status onto the port. A one-cycle trigger pulse marks the moment the last configured level fires. Software programs all registers through a simple write-only bus.

Top module: `bkpt_trigger_unit`

## Requirements
- R1: After a synchronous active-low reset, `bkpt_status` is 0000, `trig_pulse` is 0, and all compare registers and the trigger definition are zero. With `trace_busy` low, `ddata_out` is then 0000.
- R2: The program counter comparator matches in a cycle where `pc_valid` is 1 and every bit of `cpu_pc` whose mask bit is 0 equals the programmed PC value. A mask bit of 1 excludes that bit from the comparison.
- R3: The address comparator matches in a cycle where `opnd_valid` is 1 and low bound <= `opnd_addr` <= high bound (unsigned compare, both bounds inclusive).
- R4: The data comparator matches in a cycle where `opnd_valid` is 1 and every bit of `opnd_data` whose mask bit is 0 equals the programmed data value. A mask bit of 1 excludes that bit.
- R5: Register map on `reg_addr`: 0 is the trigger definition, 1 is the PC value, 2 is the PC mask, 3 is the range low bound, 4 is the range high bound, 5 is the data value and 6 is the data mask. In the trigger definition, bits [2:0] arm level 1 and bits [5:3] arm level 2, in each case with the lowest bit for PC, the middle bit for address and the highest bit for data. Bit 6 selects two-level mode, which only takes effect when bits [5:3] are nonzero. A level fires when any of its armed comparators matches. A write takes effect at the next clock edge.
- R6: A trigger definition write with a nonzero level-1 field sets the status to 0001 at the next edge. In one-level operation, a level-1 match moves the status to 0010 one cycle later, and the status then holds at 0010.
- R7: In two-level operation, a level-1 match gives 0010 for exactly one cycle, then 0101. Level-2 conditions are ignored until the status is 0101. A level-2 match at 0101 gives 0110, which then holds.
- R8: `trig_pulse` is 1 for exactly the one cycle in which the status first enters the final triggered value (0010 in one-level operation, 0110 in two-level operation) and is 0 otherwise.
- R9: Any trigger definition write restarts the sequence and takes priority over a match in the same cycle. A write with bits [2:0] all zero sets the status to 0000 at the next edge.
- R10: When `trace_busy` is 1, `ddata_out` equals `trace_data`. When it is 0, `ddata_out` is the status shifted left by one bit: 0000, 0010, 0100, 1010 or 1100 for the five status values.
- R11: `bkpt_status` only ever takes the values 0000, 0001, 0010, 0101 and 0110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| pc_valid | input | 1 | Instruction fetch address valid |
| cpu_pc | input | 32 | Instruction fetch address |
| opnd_valid | input | 1 | Operand access valid |
| opnd_addr | input | 32 | Operand address |
| opnd_data | input | 32 | Operand data |
| trace_busy | input | 1 | Debug data port is carrying trace information |
| trace_data | input | 4 | Trace nibble for the debug data port |
| ddata_out | output | 4 | Debug data port |
| bkpt_status | output | 4 | Breakpoint status |
| trig_pulse | output | 1 | One-cycle pulse when the final level fires |

## Verification
The assertions watch several properties in every cycle. They check that the status stays within the five legal codes and that the trigger pulse never lasts past one cycle and only appears alongside a triggered status. They check that the second-level triggered code can only be entered from the wait-for-level-2 code, and that waiting for level 2 is only entered from the level-1 triggered code. They also check that a cleared definition write forces the idle code and that the port's low bit is zero whenever status is shown. Only the bench scenarios can show the comparator arithmetic, meaning the masked equality and both inclusive range bounds. The same holds for ignoring level-2 matches while waiting on level 1, for write-over-match priority, and for the effective-mode rule when level 2 is unarmed.

// File: rtl/bkpt_pkg.sv
// Shared types for the breakpoint trigger unit.
// Assumes a 4-bit status; encodings are fixed by the debug data port decoding.
package bkpt_pkg;

    localparam int NUM_CMP  = 3;
    localparam int CMP_PC   = 0;
    localparam int CMP_ADDR = 1;
    localparam int CMP_DATA = 2;

    typedef enum logic [3:0] {
        ST_OFF   = 4'b0000,
        ST_WAIT1 = 4'b0001,
        ST_HIT1  = 4'b0010,
        ST_WAIT2 = 4'b0101,
        ST_HIT2  = 4'b0110
    } bkpt_state_e;

    typedef struct packed {
        logic                two_level;
        logic [NUM_CMP-1:0]  l2_en;
        logic [NUM_CMP-1:0]  l1_en;
    } trig_def_t;

endpackage

// File: rtl/bkpt_regfile.sv
// Write-only register file for the trigger unit.
// Assumes one write per cycle; new values are visible after the clock edge.
// Also forwards a same-cycle flag and the new level-1 field for definition writes.
module bkpt_regfile
    import bkpt_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int RA_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output trig_def_t         tdef,
    output logic              tdef_wr,
    output logic [NUM_CMP-1:0] tdef_new_l1,
    output logic [WORD_W-1:0] pc_val,
    output logic [WORD_W-1:0] pc_mask,
    output logic [WORD_W-1:0] rng_lo,
    output logic [WORD_W-1:0] rng_hi,
    output logic [WORD_W-1:0] dat_val,
    output logic [WORD_W-1:0] dat_mask
);
    localparam int TDEF_W = $bits(trig_def_t);
    localparam logic [RA_W-1:0] A_TDEF  = RA_W'(0);
    localparam logic [RA_W-1:0] A_PCV   = RA_W'(1);
    localparam logic [RA_W-1:0] A_PCM   = RA_W'(2);
    localparam logic [RA_W-1:0] A_LO    = RA_W'(3);
    localparam logic [RA_W-1:0] A_HI    = RA_W'(4);
    localparam logic [RA_W-1:0] A_DV    = RA_W'(5);
    localparam logic [RA_W-1:0] A_DM    = RA_W'(6);

    // Flag a definition write so the sequencer can restart in the same edge.
    assign tdef_wr     = wr_en && (wr_addr == A_TDEF);
    assign tdef_new_l1 = wr_data[NUM_CMP-1:0];

    // Capture register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdef     <= '0;
            pc_val   <= '0;
            pc_mask  <= '0;
            rng_lo   <= '0;
            rng_hi   <= '0;
            dat_val  <= '0;
            dat_mask <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_TDEF:  tdef     <= trig_def_t'(wr_data[TDEF_W-1:0]);
                A_PCV:   pc_val   <= wr_data;
                A_PCM:   pc_mask  <= wr_data;
                A_LO:    rng_lo   <= wr_data;
                A_HI:    rng_hi   <= wr_data;
                A_DV:    dat_val  <= wr_data;
                A_DM:    dat_mask <= wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bkpt_compare.sv
// Three breakpoint comparators and the per-level "any armed match" reduction.
// Purely combinational; assumes the bus qualifiers gate their own fields.
module bkpt_compare
    import bkpt_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEVELS = 2
) (
    input  logic               pc_valid,
    input  logic [WORD_W-1:0]  cpu_pc,
    input  logic               opnd_valid,
    input  logic [WORD_W-1:0]  opnd_addr,
    input  logic [WORD_W-1:0]  opnd_data,
    input  logic [WORD_W-1:0]  pc_val,
    input  logic [WORD_W-1:0]  pc_mask,
    input  logic [WORD_W-1:0]  rng_lo,
    input  logic [WORD_W-1:0]  rng_hi,
    input  logic [WORD_W-1:0]  dat_val,
    input  logic [WORD_W-1:0]  dat_mask,
    input  logic [NUM_CMP-1:0] lvl_en [LEVELS],
    output logic [LEVELS-1:0]  lvl_hit
);
    logic [NUM_CMP-1:0] cmp_hit;

    // Evaluate each comparator; mask bit 1 means "don't care".
    always_comb begin
        cmp_hit           = '0;
        cmp_hit[CMP_PC]   = pc_valid && (((cpu_pc ^ pc_val) & ~pc_mask) == '0);
        cmp_hit[CMP_ADDR] = opnd_valid && (opnd_addr >= rng_lo) && (opnd_addr <= rng_hi);
        cmp_hit[CMP_DATA] = opnd_valid && (((opnd_data ^ dat_val) & ~dat_mask) == '0);
    end

    // One reduction per trigger level.
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        assign lvl_hit[g] = |(cmp_hit & lvl_en[g]);
    end
endmodule

// File: rtl/bkpt_sequencer.sv
// Trigger level sequencer: holds the breakpoint status and raises a
// one-cycle pulse when the final configured level fires.
// Assumes a definition write restarts the sequence and outranks any match.
module bkpt_sequencer
    import bkpt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tdef_wr,
    input  logic [NUM_CMP-1:0] tdef_new_l1,
    input  logic               two_level,
    input  logic [NUM_CMP-1:0] l2_en,
    input  logic               l1_hit,
    input  logic               l2_hit,
    output bkpt_state_e        state,
    output logic               pulse
);
    bkpt_state_e nxt;
    logic        nxt_pulse;
    logic        two_eff;

    assign two_eff = two_level && (l2_en != '0);

    // Next-state and pulse decision.
    always_comb begin
        nxt       = state;
        nxt_pulse = 1'b0;
        if (tdef_wr) begin
            nxt = (tdef_new_l1 != '0) ? ST_WAIT1 : ST_OFF;
        end else begin
            case (state)
                ST_WAIT1: if (l1_hit) begin
                    nxt       = ST_HIT1;
                    nxt_pulse = !two_eff;
                end
                ST_HIT1:  if (two_eff) nxt = ST_WAIT2;
                ST_WAIT2: if (l2_hit) begin
                    nxt       = ST_HIT2;
                    nxt_pulse = 1'b1;
                end
                default:  ;
            endcase
        end
    end

    // State and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
            pulse <= 1'b0;
        end else begin
            state <= nxt;
            pulse <= nxt_pulse;
        end
    end

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state inside {ST_OFF, ST_WAIT1, ST_HIT1, ST_WAIT2, ST_HIT2}); // R11
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R8
    AST_PULSE_TRIGGERED: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (state == ST_HIT1 || state == ST_HIT2)); // R8
    AST_L2_AFTER_WAIT2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIT2 && $past(state) != ST_HIT2) |-> $past(state) == ST_WAIT2); // R7
    AST_WAIT2_AFTER_L1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT2 && $past(state) != ST_WAIT2) |-> $past(state) == ST_HIT1); // R7
    AST_CLEAR_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (tdef_wr && tdef_new_l1 == '0) |=> state == ST_OFF); // R9
endmodule

// File: rtl/bkpt_trigger_unit.sv
// Top of the non-halting two-level breakpoint trigger unit.
// Shows the encoded status on the debug data port whenever trace is idle.
// Assumes trace_busy marks every cycle the port carries trace information.
module bkpt_trigger_unit
    import bkpt_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int RA_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              pc_valid,
    input  logic [WORD_W-1:0] cpu_pc,
    input  logic              opnd_valid,
    input  logic [WORD_W-1:0] opnd_addr,
    input  logic [WORD_W-1:0] opnd_data,
    input  logic              trace_busy,
    input  logic [3:0]        trace_data,
    output logic [3:0]        ddata_out,
    output logic [3:0]        bkpt_status,
    output logic              trig_pulse
);
    localparam int LEVELS = 2;

    trig_def_t          tdef;
    logic               tdef_wr;
    logic [NUM_CMP-1:0] tdef_new_l1;
    logic [WORD_W-1:0]  pc_val, pc_mask, rng_lo, rng_hi, dat_val, dat_mask;
    logic [NUM_CMP-1:0] lvl_en [LEVELS];
    logic [LEVELS-1:0]  lvl_hit;
    bkpt_state_e        state;

    bkpt_regfile #(.WORD_W(WORD_W), .RA_W(RA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .tdef(tdef), .tdef_wr(tdef_wr),
        .tdef_new_l1(tdef_new_l1), .pc_val(pc_val), .pc_mask(pc_mask),
        .rng_lo(rng_lo), .rng_hi(rng_hi), .dat_val(dat_val), .dat_mask(dat_mask)
    );

    assign lvl_en[0] = tdef.l1_en;
    assign lvl_en[1] = tdef.l2_en;

    bkpt_compare #(.WORD_W(WORD_W), .LEVELS(LEVELS)) cmp_i (
        .pc_valid(pc_valid), .cpu_pc(cpu_pc), .opnd_valid(opnd_valid),
        .opnd_addr(opnd_addr), .opnd_data(opnd_data), .pc_val(pc_val),
        .pc_mask(pc_mask), .rng_lo(rng_lo), .rng_hi(rng_hi), .dat_val(dat_val),
        .dat_mask(dat_mask), .lvl_en(lvl_en), .lvl_hit(lvl_hit)
    );

    bkpt_sequencer seq_i (
        .clk(clk), .rst_n(rst_n), .tdef_wr(tdef_wr), .tdef_new_l1(tdef_new_l1),
        .two_level(tdef.two_level), .l2_en(tdef.l2_en),
        .l1_hit(lvl_hit[0]), .l2_hit(lvl_hit[1]),
        .state(state), .pulse(trig_pulse)
    );

    assign bkpt_status = state;

    // Share the debug data port between trace and the encoded status.
    always_comb begin
        if (trace_busy) ddata_out = trace_data;
        else            ddata_out = {bkpt_status[2:0], 1'b0};
    end

    AST_PORT_STATUS_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_busy |-> (ddata_out[0] == 1'b0 && ddata_out[3] == bkpt_status[2])); // R10
endmodule

// File: tb/bkpt_trigger_unit_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a cycle model written from the requirements.
module bkpt_trigger_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        pc_valid = 1'b0;
    logic [31:0] cpu_pc = '0;
    logic        opnd_valid = 1'b0;
    logic [31:0] opnd_addr = '0;
    logic [31:0] opnd_data = '0;
    logic        trace_busy = 1'b0;
    logic [3:0]  trace_data = '0;
    logic [3:0]  ddata_out;
    logic [3:0]  bkpt_status;
    logic        trig_pulse;

    int n_tests = 0;
    int n_fail  = 0;

    // model state
    logic [6:0]  m_tdr;
    logic [31:0] m_pcv, m_pcm, m_lo, m_hi, m_dv, m_dm;
    logic [3:0]  m_st;
    logic        m_pulse;

    always #4 clk = ~clk;

    bkpt_trigger_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pc_valid(pc_valid), .cpu_pc(cpu_pc),
        .opnd_valid(opnd_valid), .opnd_addr(opnd_addr), .opnd_data(opnd_data),
        .trace_busy(trace_busy), .trace_data(trace_data), .ddata_out(ddata_out),
        .bkpt_status(bkpt_status), .trig_pulse(trig_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] lvl_hits(input logic pv, input logic [31:0] pc,
                                            input logic ov, input logic [31:0] oa,
                                            input logic [31:0] od);
        logic [2:0] h;
        h[0] = pv && (((pc ^ m_pcv) & ~m_pcm) == 32'h0);
        h[1] = ov && (oa >= m_lo) && (oa <= m_hi);
        h[2] = ov && (((od ^ m_dv) & ~m_dm) == 32'h0);
        return {|(h & m_tdr[5:3]), |(h & m_tdr[2:0])};
    endfunction

    function automatic string tag_for(input logic [3:0] st);
        if (st == 4'b0000) return "R9";
        if (st == 4'b0101 || st == 4'b0110) return "R7";
        return "R6";
    endfunction

    // One clock: drive at negedge, advance model, check after the edge.
    task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] wd,
                        input logic pv, input logic [31:0] pc,
                        input logic ov, input logic [31:0] oa, input logic [31:0] od,
                        input logic tb, input logic [3:0] td, input string tag);
        logic [1:0] hl;
        logic       two_eff;
        @(negedge clk);
        reg_wr_en = wr; reg_addr = a; reg_wdata = wd;
        pc_valid = pv; cpu_pc = pc; opnd_valid = ov; opnd_addr = oa; opnd_data = od;
        trace_busy = tb; trace_data = td;
        hl = lvl_hits(pv, pc, ov, oa, od);
        two_eff = m_tdr[6] && (m_tdr[5:3] != 3'b000);
        m_pulse = 1'b0;
        if (wr && a == 3'd0) begin
            m_st = (wd[2:0] != 3'b000) ? 4'b0001 : 4'b0000;
        end else begin
            case (m_st)
                4'b0001: if (hl[0]) begin m_st = 4'b0010; m_pulse = !two_eff; end
                4'b0010: if (two_eff) m_st = 4'b0101;
                4'b0101: if (hl[1]) begin m_st = 4'b0110; m_pulse = 1'b1; end
                default: ;
            endcase
        end
        if (wr) begin
            case (a)
                3'd0: m_tdr = wd[6:0];
                3'd1: m_pcv = wd;
                3'd2: m_pcm = wd;
                3'd3: m_lo  = wd;
                3'd4: m_hi  = wd;
                3'd5: m_dv  = wd;
                3'd6: m_dm  = wd;
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        chk((tag != "") ? tag : tag_for(m_st), bkpt_status, m_st);
        chk("R8", trig_pulse, m_pulse);
        chk("R10", ddata_out, tb ? td : {m_st[2:0], 1'b0});
        chk("R11", (m_st inside {4'h0, 4'h1, 4'h2, 4'h5, 4'h6}) ? 1 : 0, 1);
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d, input string tag);
        step(1'b1, a, d, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 1'b0, 4'h0, tag);
    endtask

    task automatic pcacc(input logic [31:0] pc, input string tag);
        step(1'b0, 3'd0, 32'h0, 1'b1, pc, 1'b0, 32'h0, 32'h0, 1'b0, 4'h0, tag);
    endtask

    task automatic opacc(input logic ov, input logic [31:0] oa, input logic [31:0] od,
                         input string tag);
        step(1'b0, 3'd0, 32'h0, 1'b0, 32'h0, ov, oa, od, 1'b0, 4'h0, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 3'd0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 1'b0, 4'h0, tag);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        m_tdr = '0; m_pcv = '0; m_pcm = '0; m_lo = '0; m_hi = '0; m_dv = '0; m_dm = '0;
        m_st = '0; m_pulse = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", bkpt_status, 4'h0);
        chk("R1", trig_pulse, 1'b0);
        chk("R1", ddata_out, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1");

        // R2: masked PC compare, one-level
        wreg(3'd1, 32'h0000_1000, "R5");
        wreg(3'd2, 32'h0000_000F, "R5");
        wreg(3'd0, 32'h0000_0001, "R6");
        pcacc(32'h0000_2000, "R2");
        step(1'b0, 3'd0, 32'h0, 1'b0, 32'h0000_100A, 1'b0, 32'h0, 32'h0, 1'b0, 4'h0, "R2");
        pcacc(32'h0000_100A, "R2");
        idle("R6");
        pcacc(32'h0000_1003, "R6");

        // R3: inclusive address window
        wreg(3'd3, 32'h0000_0100, "R5");
        wreg(3'd4, 32'h0000_01FF, "R5");
        wreg(3'd0, 32'h0000_0002, "R6");
        opacc(1'b1, 32'h0000_00FF, 32'h0, "R3");
        opacc(1'b1, 32'h0000_0200, 32'h0, "R3");
        opacc(1'b0, 32'h0000_0150, 32'h0, "R3");
        opacc(1'b1, 32'h0000_01FF, 32'h0, "R3");
        wreg(3'd0, 32'h0000_0002, "R9");
        opacc(1'b1, 32'h0000_0100, 32'h0, "R3");

        // R4: masked data compare
        wreg(3'd5, 32'hA5A5_0000, "R5");
        wreg(3'd6, 32'h0000_FFFF, "R5");
        wreg(3'd0, 32'h0000_0004, "R6");
        opacc(1'b1, 32'h0, 32'hA5A4_1234, "R4");
        opacc(1'b1, 32'h0, 32'hA5A5_BEEF, "R4");
        idle("R4");

        // R7: two-level, level-1 PC then level-2 data
        wreg(3'd0, 32'h0000_0061, "R7");
        opacc(1'b1, 32'h0, 32'hA5A5_0001, "R7");
        pcacc(32'h0000_1005, "R7");
        idle("R7");
        pcacc(32'h0000_1005, "R7");
        opacc(1'b1, 32'h0, 32'hA5A5_0002, "R7");
        idle("R7");

        // R9: write outranks match; cleared write idles
        wreg(3'd0, 32'h0000_0001, "R9");
        step(1'b1, 3'd0, 32'h0000_0001, 1'b1, 32'h0000_1000, 1'b0, 32'h0, 32'h0, 1'b0, 4'h0, "R9");
        wreg(3'd0, 32'h0000_0000, "R9");
        pcacc(32'h0000_1000, "R9");

        // R5: two-level bit without level-2 arms behaves one-level
        wreg(3'd0, 32'h0000_0041, "R5");
        pcacc(32'h0000_1000, "R5");
        idle("R5");

        // R10: trace owns the port while busy
        for (int i = 0; i < 8; i++)
            step(1'b0, 3'd0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 1'b1, 4'($urandom()), "R10");

        // Random traffic near the programmed values
        for (int i = 0; i < 1500; i++) begin
            logic wr;
            logic [2:0] a;
            logic [31:0] wd;
            wr = ($urandom() % 16) == 0;
            a  = 3'($urandom() % 7);
            wd = (a == 3'd0) ? 32'($urandom() % 128) : 32'h0000_1000 + ($urandom() % 512);
            if (a == 3'd2 || a == 3'd6) wd = 32'($urandom() % 16);
            step(wr, a, wd,
                 1'($urandom()), 32'h0000_1000 + ($urandom() % 32),
                 1'($urandom()), 32'h0000_1000 + ($urandom() % 600),
                 32'h0000_1000 + ($urandom() % 32),
                 ($urandom() % 4) == 0, 4'($urandom()), "");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule